// File: doc/BRIEF.md
# Cycle-to-Sample Rate Scheduler

This block sits between an instruction engine that reports how many CPU cycles each step consumed and an audio path that needs a strobe once per output sample. It keeps a fixed-point cycle accumulator with four fractional bits. It holds a frame-cycle counter that raises a one-cycle event whenever a video frame's worth of cycles has passed, and that event is used to start the next player call. A tenths/seconds time-of-day counter advances on the sample strobe. It also holds a mixer attenuation value selected by how many sound chips are active.

A configuration load latches the sample rate, the video standard and the chip count. It then computes two quotients in sequence on one shared sequential divider: the cycles-per-sample ratio and the tenth-second reload. Step reports are ignored until both quotients are ready. The CPU core, sound synthesis and memory sit outside the block.

Top module: `cycle_sample_sched`

## Requirements
- R1: After reset, `cfg_ready`, `sample_tick` and `frame_tick` are 0. `tod_tenths`, `tod_seconds` and `attenuation` are 0, and `is_pal` is 1.
- R2: A `cfg_load` sampled while no computation is in progress drops `cfg_ready`. `cfg_ready` returns to 1 within 56 cycles. While `cfg_ready` is 0, step reports are ignored, `sample_tick` and `frame_tick` stay 0, and a further `cfg_load` is ignored.
- R3: The video standard is NTSC when `cfg_video_sel` equals 2 and PAL for the values 0, 1 and 3, and `is_pal` shows the result. The CPU clock constant is 985248 for PAL and 1022727 for NTSC.
- R4: Each accepted step contributes a number of cycles set by `step_kind`. Kind 0 contributes `step_cycles`, kind 1 (idle) contributes 7, kind 2 (routine finished) contributes 6, and kind 3 contributes 0.
- R5: A sample rate of 0 selects 44100. The ratio is floor(clock×16 / rate). Each accepted step adds cycles×16 to the accumulator. In any cycle where the accumulator exceeds the ratio, `sample_tick` is 1, and at the next edge the ratio is subtracted and the remainder is kept.
- R6: The frame period is 312×63 cycles for PAL and 263×65 for NTSC. When the frame counter plus a step's cycles reaches the period, the period is subtracted and `frame_tick` is 1 for the following cycle only.
- R7: A down-counter is loaded with floor(rate/10) and decremented on each sample tick. On a tick that finds it at 1 or below, it reloads and `tod_tenths` increments. `tod_tenths` wraps from 9 to 0 and carries into the 8-bit wrapping `tod_seconds`.
- R8: `attenuation` is 0, 26, 43 or 137 for a latched chip count of 0, 1, 2 or 3.
- R9: An accepted `cfg_load` clears the accumulator, the frame counter and both time-of-day digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Latch configuration and start the divides |
| cfg_rate | input | 16 | Sample rate in Hz, 0 selects 44100 |
| cfg_video_sel | input | 2 | Video-standard field of the tune header (2 = NTSC) |
| cfg_chips | input | 2 | Number of active sound chips |
| step_valid | input | 1 | A step report is present |
| step_kind | input | 2 | 0 execute, 1 idle, 2 finished, 3 none |
| step_cycles | input | 4 | Cycle count for an execute step |
| cfg_ready | output | 1 | Quotients valid, steps accepted |
| is_pal | output | 1 | Latched video standard is PAL |
| attenuation | output | 8 | Mixer attenuation for the chip count |
| sample_tick | output | 1 | One output sample is due this cycle |
| frame_tick | output | 1 | A frame period has elapsed |
| tod_tenths | output | 4 | Tenth-of-second digit |
| tod_seconds | output | 8 | Seconds count |

## Verification
`sample_tick` is a function of registered accumulator state. It therefore appears in the cycle right after the edge that took in the crossing step, and it is compared in that same cycle. `frame_tick` is registered, so it is due one cycle after the step that completed a frame. The time-of-day digits change at the edge that closes a tick cycle. The bench keeps a reference model that advances once per clock with the inputs it drove. It compares all four results at each falling edge, before the model steps forward. After a load, the bench polls `cfg_ready` at falling edges, checks that the wait stays within the bound, and only then starts the model from cleared state.

// File: rtl/css_pkg.sv
package css_pkg;

  localparam int unsigned PAL_CPU_HZ    = 985248;
  localparam int unsigned NTSC_CPU_HZ   = 1022727;
  localparam int unsigned PAL_LINES     = 312;
  localparam int unsigned PAL_LINE_CYC  = 63;
  localparam int unsigned NTSC_LINES    = 263;
  localparam int unsigned NTSC_LINE_CYC = 65;
  localparam int unsigned FRAC_BITS     = 4;

  typedef enum logic [1:0] {
    STEP_EXEC   = 2'd0,
    STEP_IDLE   = 2'd1,
    STEP_FINISH = 2'd2,
    STEP_NONE   = 2'd3
  } step_kind_e;

  function automatic int unsigned cpu_hz(input logic pal);
    return pal ? PAL_CPU_HZ : NTSC_CPU_HZ;
  endfunction

  function automatic int unsigned frame_cycles(input logic pal);
    return pal ? (PAL_LINES * PAL_LINE_CYC) : (NTSC_LINES * NTSC_LINE_CYC);
  endfunction

  function automatic logic [7:0] mix_atten(input logic [1:0] chips);
    case (chips)
      2'd0:    return 8'd0;
      2'd1:    return 8'd26;
      2'd2:    return 8'd43;
      default: return 8'd137;
    endcase
  endfunction

endpackage

// File: rtl/css_divider.sv
module css_divider #(
  parameter int N_W = 24,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quotient
);

  localparam int CNT_W = $clog2(N_W + 1);
  localparam int P_W   = N_W + D_W;

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [D_W-1:0]   rem_q, rem_d;
  logic [N_W-1:0]   quo_q, quo_d;
  logic [N_W-1:0]   dvd_q, dvd_d;
  logic [D_W-1:0]   dvs_q, dvs_d;
  logic [D_W:0]     shifted;
  logic [D_W:0]     trial;

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvd_d   = dvd_q;
    dvs_d   = dvs_q;
    shifted = {rem_q, quo_q[N_W-1]};
    trial   = shifted - {1'b0, dvs_q};
    if (busy_q) begin
      if (shifted >= {1'b0, dvs_q}) begin
        rem_d = trial[D_W-1:0];
        quo_d = {quo_q[N_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[D_W-1:0];
        quo_d = {quo_q[N_W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(N_W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = '0;
      quo_d  = dividend;
      dvd_d  = dividend;
      dvs_d  = divisor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvd_q  <= dvd_d;
      dvs_q  <= dvs_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R5: quotient and remainder are consistent with the latched operands
  assert_div_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((P_W'(quo_q) * P_W'(dvs_q) + P_W'(rem_q)) == P_W'(dvd_q)) && (rem_q < dvs_q));

endmodule

// File: rtl/css_config.sv
module css_config
  import css_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int CLK_W    = 24,
  parameter int FRM_W    = 16,
  parameter int ATT_W    = 8,
  parameter int DEF_RATE = 44100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [1:0]        cfg_video_sel,
  input  logic [1:0]        cfg_chips,
  output logic              ready,
  output logic              is_pal,
  output logic [ATT_W-1:0]  atten,
  output logic [CLK_W-1:0]  ratio,
  output logic [RATE_W-1:0] tenth,
  output logic [FRM_W-1:0]  period,
  output logic              clear,
  output logic              tod_load
);

  typedef enum logic [1:0] {CF_IDLE, CF_RATIO, CF_TENTH} cf_state_e;

  cf_state_e         state_q, state_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              pal_q, pal_d;
  logic [1:0]        chips_q, chips_d;
  logic [CLK_W-1:0]  ratio_q, ratio_d;
  logic [RATE_W-1:0] tenth_q, tenth_d;
  logic              ready_q, ready_d;
  logic              tload_q, tload_d;

  logic              accept;
  logic [RATE_W-1:0] rate_in;
  logic              pal_in;
  logic              div_start, div_busy, div_done;
  logic [CLK_W-1:0]  div_dividend, div_quo;
  logic [RATE_W-1:0] div_divisor;

  assign accept  = cfg_load && (state_q == CF_IDLE);
  assign rate_in = (cfg_rate == '0) ? RATE_W'(DEF_RATE) : cfg_rate;
  assign pal_in  = (cfg_video_sel != 2'b10);

  always_comb begin
    state_d      = state_q;
    rate_d       = rate_q;
    pal_d        = pal_q;
    chips_d      = chips_q;
    ratio_d      = ratio_q;
    tenth_d      = tenth_q;
    ready_d      = ready_q;
    tload_d      = 1'b0;
    div_start    = 1'b0;
    div_dividend = CLK_W'(rate_q);
    div_divisor  = RATE_W'(10);
    case (state_q)
      CF_IDLE: begin
        if (accept) begin
          div_start    = 1'b1;
          div_dividend = CLK_W'(cpu_hz(pal_in) << FRAC_BITS);
          div_divisor  = rate_in;
          rate_d       = rate_in;
          pal_d        = pal_in;
          chips_d      = cfg_chips;
          ready_d      = 1'b0;
          state_d      = CF_RATIO;
        end
      end
      CF_RATIO: begin
        if (div_done) begin
          ratio_d   = div_quo;
          div_start = 1'b1;
          state_d   = CF_TENTH;
        end
      end
      CF_TENTH: begin
        if (div_done) begin
          tenth_d = div_quo[RATE_W-1:0];
          ready_d = 1'b1;
          tload_d = 1'b1;
          state_d = CF_IDLE;
        end
      end
      default: state_d = CF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CF_IDLE;
      rate_q  <= '0;
      pal_q   <= 1'b1;
      chips_q <= '0;
      ratio_q <= '0;
      tenth_q <= '0;
      ready_q <= 1'b0;
      tload_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_d;
      pal_q   <= pal_d;
      chips_q <= chips_d;
      ratio_q <= ratio_d;
      tenth_q <= tenth_d;
      ready_q <= ready_d;
      tload_q <= tload_d;
    end
  end

  css_divider #(.N_W(CLK_W), .D_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  assign ready    = ready_q;
  assign is_pal   = pal_q;
  assign atten    = ATT_W'(mix_atten(chips_q));
  assign ratio    = ratio_q;
  assign tenth    = tenth_q;
  assign period   = FRM_W'(frame_cycles(pal_q));
  assign clear    = accept;
  assign tod_load = tload_q;

  // R2: quotients are only published once the divider is idle
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !div_busy);

  // R8: attenuation only takes the four table values
  assert_atten_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (atten == ATT_W'(0)) || (atten == ATT_W'(26)) || (atten == ATT_W'(43)) || (atten == ATT_W'(137)));

endmodule

// File: rtl/css_accum.sv
module css_accum
  import css_pkg::*;
#(
  parameter int CLK_W = 24,
  parameter int CYC_W = 4,
  parameter int FRM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ready,
  input  logic             step_valid,
  input  logic [CYC_W-1:0] step_cycles,
  input  logic [CLK_W-1:0] ratio,
  input  logic [FRM_W-1:0] period,
  output logic             sample_tick,
  output logic             frame_tick
);

  localparam int ACC_W = CLK_W + 2;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic             ftick_q, ftick_d;
  logic             take;
  logic [ACC_W-1:0] add_fx;
  logic [ACC_W-1:0] acc_base;
  logic [FRM_W:0]   frm_sum;

  assign take        = ready && step_valid;
  assign sample_tick = ready && (acc_q > ACC_W'(ratio));
  assign add_fx      = take ? (ACC_W'(step_cycles) << FRAC_BITS) : '0;
  assign acc_base    = sample_tick ? (acc_q - ACC_W'(ratio)) : acc_q;
  assign frm_sum     = (FRM_W+1)'(frm_q) + (FRM_W+1)'(step_cycles);

  always_comb begin
    acc_d   = acc_q;
    frm_d   = frm_q;
    ftick_d = 1'b0;
    if (clear) begin
      acc_d = '0;
      frm_d = '0;
    end else if (ready) begin
      acc_d = acc_base + add_fx;
      if (take) begin
        if (frm_sum >= (FRM_W+1)'(period)) begin
          frm_d   = FRM_W'(frm_sum - (FRM_W+1)'(period));
          ftick_d = 1'b1;
        end else begin
          frm_d = FRM_W'(frm_sum);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      frm_q   <= '0;
      ftick_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      frm_q   <= frm_d;
      ftick_q <= ftick_d;
    end
  end

  assign frame_tick = ftick_q;

  // R5: a sample drains at least as much as one step can add
  assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !clear) |=> (acc_q <= $past(acc_q)));

  // R6: the frame counter stays below one period while running
  assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (frm_q < period));

  // R2: no frame event while the quotients are not valid
  assert_quiet_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !frame_tick);

endmodule

// File: rtl/css_tod.sv
module css_tod #(
  parameter int RATE_W = 16,
  parameter int SEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [RATE_W-1:0] reload_val,
  input  logic              tick,
  output logic [3:0]        tenths,
  output logic [SEC_W-1:0]  seconds
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [3:0]        ten_q, ten_d;
  logic [SEC_W-1:0]  sec_q, sec_d;

  always_comb begin
    cnt_d = cnt_q;
    ten_d = ten_q;
    sec_d = sec_q;
    if (clear) begin
      cnt_d = '0;
      ten_d = '0;
      sec_d = '0;
    end else if (load) begin
      cnt_d = reload_val;
    end else if (tick) begin
      if (cnt_q <= RATE_W'(1)) begin
        cnt_d = reload_val;
        if (ten_q == 4'd9) begin
          ten_d = '0;
          sec_d = sec_q + 1'b1;
        end else begin
          ten_d = ten_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ten_q <= '0;
      sec_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ten_q <= ten_d;
      sec_q <= sec_d;
    end
  end

  assign tenths  = ten_q;
  assign seconds = sec_q;

  // R7: tenths digit never leaves 0..9
  assert_tenths_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ten_q <= 4'd9);

  // R7: a 9 to 0 wrap that is not a clear carries into seconds
  assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ten_q) == 4'd9 && ten_q == 4'd0 && !$past(clear)) |-> (sec_q == $past(sec_q) + 1'b1));

endmodule

// File: rtl/cycle_sample_sched.sv
module cycle_sample_sched
  import css_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int CLK_W    = 24,
  parameter int CYC_W    = 4,
  parameter int FRM_W    = 16,
  parameter int ATT_W    = 8,
  parameter int SEC_W    = 8,
  parameter int DEF_RATE = 44100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [1:0]        cfg_video_sel,
  input  logic [1:0]        cfg_chips,
  input  logic              step_valid,
  input  logic [1:0]        step_kind,
  input  logic [CYC_W-1:0]  step_cycles,
  output logic              cfg_ready,
  output logic              is_pal,
  output logic [ATT_W-1:0]  attenuation,
  output logic              sample_tick,
  output logic              frame_tick,
  output logic [3:0]        tod_tenths,
  output logic [SEC_W-1:0]  tod_seconds
);

  logic              ready;
  logic              clear;
  logic              tod_load;
  logic [CLK_W-1:0]  ratio;
  logic [RATE_W-1:0] tenth;
  logic [FRM_W-1:0]  period;
  logic [CYC_W-1:0]  cyc;
  logic              tick;

  // R4: cycles charged per step kind
  always_comb begin
    case (step_kind_e'(step_kind))
      STEP_EXEC:   cyc = step_cycles;
      STEP_IDLE:   cyc = CYC_W'(7);
      STEP_FINISH: cyc = CYC_W'(6);
      default:     cyc = '0;
    endcase
  end

  css_config #(
    .RATE_W(RATE_W), .CLK_W(CLK_W), .FRM_W(FRM_W), .ATT_W(ATT_W), .DEF_RATE(DEF_RATE)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .cfg_rate      (cfg_rate),
    .cfg_video_sel (cfg_video_sel),
    .cfg_chips     (cfg_chips),
    .ready         (ready),
    .is_pal        (is_pal),
    .atten         (attenuation),
    .ratio         (ratio),
    .tenth         (tenth),
    .period        (period),
    .clear         (clear),
    .tod_load      (tod_load)
  );

  css_accum #(.CLK_W(CLK_W), .CYC_W(CYC_W), .FRM_W(FRM_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .ready       (ready),
    .step_valid  (step_valid),
    .step_cycles (cyc),
    .ratio       (ratio),
    .period      (period),
    .sample_tick (tick),
    .frame_tick  (frame_tick)
  );

  css_tod #(.RATE_W(RATE_W), .SEC_W(SEC_W)) u_tod (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .load       (tod_load),
    .reload_val (tenth),
    .tick       (tick),
    .tenths     (tod_tenths),
    .seconds    (tod_seconds)
  );

  assign cfg_ready   = ready;
  assign sample_tick = tick;

  // R9: an accepted load leaves cleared digits behind
  assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tod_tenths == 4'd0 && tod_seconds == '0 && !frame_tick));

endmodule

// File: tb/cycle_sample_sched_tb.sv
module cycle_sample_sched_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [15:0] cfg_rate;
  logic [1:0]  cfg_video_sel;
  logic [1:0]  cfg_chips;
  logic        step_valid;
  logic [1:0]  step_kind;
  logic [3:0]  step_cycles;
  logic        cfg_ready, is_pal, sample_tick, frame_tick;
  logic [7:0]  attenuation;
  logic [3:0]  tod_tenths;
  logic [7:0]  tod_seconds;

  always #5 clk = ~clk;

  cycle_sample_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_rate(cfg_rate),
    .cfg_video_sel(cfg_video_sel), .cfg_chips(cfg_chips), .step_valid(step_valid),
    .step_kind(step_kind), .step_cycles(step_cycles), .cfg_ready(cfg_ready),
    .is_pal(is_pal), .attenuation(attenuation), .sample_tick(sample_tick),
    .frame_tick(frame_tick), .tod_tenths(tod_tenths), .tod_seconds(tod_seconds)
  );

  int  vectors = 0;
  int  fails   = 0;
  bit  finished = 0;

  // reference model state
  longint m_acc, m_ratio, m_fc, m_period;
  int     m_cnt, m_tenth, m_tenths, m_secs;
  bit     m_ftick, m_run;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R4: cycle charge per step kind
  function automatic int cyc_of(input logic [1:0] k, input logic [3:0] c);
    case (k)
      2'd0:    return int'(c);
      2'd1:    return 7;
      2'd2:    return 6;
      default: return 0;
    endcase
  endfunction

  function automatic longint exp_ratio(input bit pal, input int rate);
    return ((pal ? 64'd985248 : 64'd1022727) * 16) / rate;
  endfunction

  task automatic run_step(input bit v, input logic [1:0] k, input logic [3:0] c, input bit ld);
    bit     exp_tick;
    int     add;
    longint s;
    step_valid  = v;
    step_kind   = k;
    step_cycles = c;
    cfg_load    = ld;
    if (m_run) begin
      exp_tick = (m_acc > m_ratio);
      chk(sample_tick == exp_tick, "R5", "sample_tick", sample_tick, exp_tick);
      chk(frame_tick == m_ftick, "R6", "frame_tick", frame_tick, m_ftick);
      chk(tod_tenths == m_tenths, "R7", "tod_tenths", tod_tenths, m_tenths);
      chk(tod_seconds == m_secs, "R7", "tod_seconds", tod_seconds, m_secs);
      add = v ? cyc_of(k, c) : 0;
      m_acc = (exp_tick ? m_acc - m_ratio : m_acc) + add * 16;
      m_ftick = 0;
      if (v) begin
        s = m_fc + add;
        if (s >= m_period) begin
          m_fc = s - m_period;
          m_ftick = 1;
        end else m_fc = s;
      end
      if (exp_tick) begin
        if (m_cnt <= 1) begin
          m_cnt = m_tenth;
          if (m_tenths == 9) begin
            m_tenths = 0;
            m_secs = (m_secs + 1) % 256;
          end else m_tenths++;
        end else m_cnt--;
      end
    end else begin
      chk(sample_tick == 1'b0, "R2", "sample_tick while not ready", sample_tick, 0);
      chk(frame_tick == 1'b0, "R2", "frame_tick while not ready", frame_tick, 0);
    end
    @(negedge clk);
  endtask

  task automatic rand_step(input bit ld);
    run_step(1'b1, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), ld);
  endtask

  task automatic configure(input int rate, input logic [1:0] vsel, input logic [1:0] chips,
                           input int exp_att, input bit exp_pal);
    int n;
    int rate_eff;
    cfg_rate = 16'(rate);
    cfg_video_sel = vsel;
    cfg_chips = chips;
    rand_step(1'b1);
    m_run = 0;
    // a second load while busy must be ignored (R2)
    cfg_rate = 16'd123;
    cfg_video_sel = 2'b10;
    cfg_chips = 2'd3 - chips;
    n = 0;
    while (!cfg_ready && n < 100) begin
      rand_step(n == 2);
      n++;
    end
    chk(n <= 56, "R2", "ready latency", n, 56);
    chk(is_pal == exp_pal, "R3", "is_pal", is_pal, exp_pal);
    chk(attenuation == 8'(exp_att), "R8", "attenuation", attenuation, exp_att);
    chk(tod_tenths == 0 && tod_seconds == 0, "R9", "digits after load", tod_seconds, 0);
    rate_eff = (rate == 0) ? 44100 : rate;   // R5 default rate
    m_ratio  = exp_ratio(exp_pal, rate_eff);
    m_tenth  = rate_eff / 10;
    m_period = exp_pal ? 312 * 63 : 263 * 65;
    m_acc = 0; m_fc = 0; m_ftick = 0; m_cnt = m_tenth; m_tenths = 0; m_secs = 0;
    m_run = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_load = 0; cfg_rate = 0; cfg_video_sel = 0; cfg_chips = 0;
    step_valid = 0; step_kind = 0; step_cycles = 0; m_run = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_ready == 0, "R1", "cfg_ready", cfg_ready, 0);
    chk(sample_tick == 0 && frame_tick == 0, "R1", "ticks", sample_tick, 0);
    chk(tod_tenths == 0 && tod_seconds == 0, "R1", "tod", tod_seconds, 0);
    chk(attenuation == 0, "R1", "attenuation", attenuation, 0);
    chk(is_pal == 1, "R1", "is_pal", is_pal, 1);

    // R2: steps before any configuration are ignored
    for (int i = 0; i < 30; i++) rand_step(1'b0);

    // default rate, PAL, one chip
    configure(0, 2'b00, 2'd1, 26, 1);
    // R4 R6: 2808 idle steps are exactly one PAL frame
    for (int i = 0; i < 2808; i++) begin
      chk(frame_tick == 0, "R4", "early frame on idle", frame_tick, 0);
      run_step(1'b1, 2'd1, 4'd0, 1'b0);
    end
    chk(frame_tick == 1, "R4", "frame after 2808 idle steps", frame_tick, 1);
    // R4 R6: 3276 finished steps are exactly one PAL frame
    for (int i = 0; i < 3276; i++) run_step(1'b1, 2'd2, 4'd0, 1'b0);
    chk(frame_tick == 1, "R4", "frame after 3276 finish steps", frame_tick, 1);
    for (int i = 0; i < 6000; i++) rand_step(1'b0);

    // NTSC, three chips
    configure(8000, 2'b10, 2'd3, 137, 0);
    for (int i = 0; i < 12000; i++) rand_step(1'b0);

    // R7: tenth reload of 1, run past a seconds carry; field value 3 is PAL (R3)
    configure(10, 2'b11, 2'd2, 43, 1);
    for (int i = 0; i < 72000; i++) run_step(1'b1, 2'd0, 4'd15, 1'b0);
    chk(tod_seconds >= 1, "R7", "seconds carry reached", tod_seconds, 1);

    // R5: highest rate, ratio of 240 against full-size steps
    configure(65535, 2'b01, 2'd0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 1) == 0) run_step(1'b1, 2'd0, 4'd15, 1'b0);
      else rand_step(1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule